// File: doc/BRIEF.md
# Prefix-Aware Effective Address Generator

This block sits between the instruction fetch path and the execute stage of an 8-bit accumulator processor. It takes bytes from the fetch port one at a time. It recognises an optional prefix byte and decodes the opcode's high nibble into an addressing mode. It then consumes the operand bytes that mode needs and produces the 16-bit effective address. A prefix can switch indexing from X to Y, turn on memory-indirect addressing, or both. For indirect forms the block fetches the pointer bytes itself through a simple request/valid memory read port.

When the address is resolved, `done` pulses for one cycle. In that cycle the address, a mode tag, the selected index register and the extra cycle cost of the prefix are all valid. The block then returns to waiting for the next instruction. Executing the operation and bank-extended indirect forms are handled elsewhere. The caller drives `instrPc` with the address of the byte currently offered on the fetch port, so the block can place immediate operands.

Top module: `prefix_ea_gen`

## Requirements
- R1: After reset is released, `fetchReady` is 1 and both `memReq` and `done` are 0.
- R2: A prefix byte 0x90 selects Y as the index (`useY`=1) and gives `extraCycles`=1, with no pointer reads.
- R3: A prefix byte 0x91 selects Y as the index and indirect addressing, and gives `extraCycles`=2.
- R4: A prefix byte 0x92 selects X with indirect addressing and gives `extraCycles`=2. With no prefix, the block uses X, direct addressing and `extraCycles`=0.
- R5: A prefix value that arrives directly after a prefix is taken as the opcode. Its high nibble 9 gives the no-address mode.
- R6: Immediate mode (high nibble A) consumes one operand byte, and `ea` is the address of the byte that follows the opcode.
- R7: Direct forms: nibbles 3, B, 0 and 1 give `ea` = {0x00, operand}. Nibble C takes two operand bytes, with the first one as the high byte.
- R8: Indexed forms add the selected index, zero-extended, to the base, modulo 2^16. Nibble D uses a 16-bit base, nibbles 6 and E use {0x00, operand}, and nibbles 7 and F give `ea` = index.
- R9: Short indirect applies to nibbles 3, B, 6, E, 0 and 1. The block makes one read at {0x00, operand}, and the byte returned replaces the operand as the base.
- R10: Long indirect applies to nibbles C and D. The block takes one operand byte P and reads P and then P+1 (a 16-bit sum). The two bytes form the base, high byte first, and no second operand byte is taken.
- R11: Indirect addressing has no effect for nibbles A, 7, F, 4, 5, 2, 8 and 9: no read is made. Nibbles 4, 5, 2, 8 and 9 report `ea` = 0.
- R12: The `mode` tag encodes the addressing mode as follows: 0 none (2, 8, 9), 1 immediate, 2 short direct, 3 long direct, 4 long indexed, 5 short indexed, 6 index only, 7 inherent A, 8 inherent X/Y, 9 bit manipulation (0, 1).
- R13: Once `memReq` is raised, it stays high with a stable `memAddr` until `memValid` is seen.
- R14: `done` lasts exactly one cycle, and `fetchReady` and `memReq` are both low while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A fetch byte is offered |
| fetchByte | input | 8 | Offered instruction byte |
| instrPc | input | 16 | Address of the offered byte |
| fetchReady | output | 1 | Block accepts a byte this cycle |
| memReq | output | 1 | Pointer read request |
| memAddr | output | 16 | Pointer read address |
| memValid | input | 1 | Read data is present, and the request completes |
| memData | input | 8 | Read data |
| xIdx | input | 8 | X index register value |
| yIdx | input | 8 | Y index register value |
| done | output | 1 | Address resolved (one-cycle pulse) |
| ea | output | 16 | Effective address |
| mode | output | 4 | Addressing mode tag |
| useY | output | 1 | Y was selected as the index |
| extraCycles | output | 2 | Extra cycles added by the prefix |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 16-bit address and prefix codes 0x90, 0x91 and 0x92. With these values the interesting edges are in reach. A long indexed base of 0xFFF0 plus an index of 0x20 wraps to 0x0010. A page-zero pointer at 0xFF reads its low byte from 0x0100. An immediate opcode at 0xFFFF places its operand at 0x0000. Random opcodes under every prefix cover all sixteen high nibbles, with gaps on the fetch port and stalls on the read port.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [3:0] {
    MD_NONE    = 4'd0,
    MD_IMM     = 4'd1,
    MD_DIR8    = 4'd2,
    MD_DIR16   = 4'd3,
    MD_IDX16   = 4'd4,
    MD_IDX8    = 4'd5,
    MD_IDXONLY = 4'd6,
    MD_INH_A   = 4'd7,
    MD_INH_XY  = 4'd8,
    MD_BIT     = 4'd9
  } eaMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic firstByte;   // byte on the port starts a new instruction
    logic takeByte;    // a fetch byte is consumed this cycle
    logic capOp1;      // first operand byte
    logic capOp2;      // second operand byte (long direct)
    logic capPtrHi;    // pointer read returns the high byte
    logic capPtrLo;    // pointer read returns the low (or only) byte
    logic ptrPlusOne;  // second pointer read address
  } eagStrobe_t;

  function automatic eaMode_t modeOfNibble(input logic [3:0] nib);
    eaMode_t m;
    case (nib)
      4'h0, 4'h1: m = MD_BIT;
      4'h3, 4'hB: m = MD_DIR8;
      4'h4:       m = MD_INH_A;
      4'h5:       m = MD_INH_XY;
      4'h6, 4'hE: m = MD_IDX8;
      4'h7, 4'hF: m = MD_IDXONLY;
      4'hA:       m = MD_IMM;
      4'hC:       m = MD_DIR16;
      4'hD:       m = MD_IDX16;
      default:    m = MD_NONE;
    endcase
    return m;
  endfunction

  function automatic logic isLongMode(input eaMode_t m);
    return (m == MD_DIR16) || (m == MD_IDX16);
  endfunction

  function automatic logic isShortPtrMode(input eaMode_t m);
    return (m == MD_DIR8) || (m == MD_IDX8) || (m == MD_BIT);
  endfunction

  function automatic logic hasOperand(input eaMode_t m);
    return isLongMode(m) || isShortPtrMode(m) || (m == MD_IMM);
  endfunction

endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] PFX_Y     = 8'h90,
  parameter logic [DW-1:0] PFX_Y_IND = 8'h91,
  parameter logic [DW-1:0] PFX_IND   = 8'h92
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fetchValid,
  input  logic [DW-1:0] fetchByte,
  input  logic          memValid,
  output logic          fetchReady,
  output logic          memReq,
  output logic          done,
  output logic          useY,
  output logic          indirect,
  output logic [1:0]    extraCycles,
  output eaMode_t       mode,
  output eagStrobe_t    strb
);

  typedef enum logic [2:0] {
    ST_OPC, ST_OP1, ST_OP2, ST_RD1, ST_RD2, ST_DONE
  } ctrlState_t;

  ctrlState_t state, stateNx;
  logic       prefSeen;
  logic       take;
  logic       isPfx;
  eaMode_t    byteMode;

  assign fetchReady = (state == ST_OPC) || (state == ST_OP1) || (state == ST_OP2);
  assign memReq     = (state == ST_RD1) || (state == ST_RD2);
  assign done       = (state == ST_DONE);
  assign take       = fetchValid && fetchReady;
  assign byteMode   = modeOfNibble(fetchByte[DW-1 -: 4]);
  assign isPfx      = !prefSeen &&
                      ((fetchByte == PFX_Y) || (fetchByte == PFX_Y_IND) || (fetchByte == PFX_IND));

  always_comb begin
    stateNx = state;
    case (state)
      ST_OPC:
        if (take && !isPfx) stateNx = hasOperand(byteMode) ? ST_OP1 : ST_DONE;
      ST_OP1:
        if (take) begin
          if (isLongMode(mode))                      stateNx = indirect ? ST_RD1 : ST_OP2;
          else if (isShortPtrMode(mode) && indirect) stateNx = ST_RD1;
          else                                       stateNx = ST_DONE;
        end
      ST_OP2:
        if (take) stateNx = ST_DONE;
      ST_RD1:
        if (memValid) stateNx = isLongMode(mode) ? ST_RD2 : ST_DONE;
      ST_RD2:
        if (memValid) stateNx = ST_DONE;
      default:
        stateNx = ST_OPC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_OPC;
      prefSeen    <= 1'b0;
      useY        <= 1'b0;
      indirect    <= 1'b0;
      extraCycles <= 2'd0;
      mode        <= MD_NONE;
    end else begin
      state <= stateNx;
      if (state == ST_OPC && take) begin
        if (isPfx) begin
          prefSeen    <= 1'b1;
          useY        <= (fetchByte == PFX_Y) || (fetchByte == PFX_Y_IND);
          indirect    <= (fetchByte == PFX_Y_IND) || (fetchByte == PFX_IND);
          extraCycles <= (fetchByte == PFX_Y) ? 2'd1 : 2'd2;
        end else begin
          prefSeen <= 1'b0;
          mode     <= byteMode;
        end
      end
      if (state == ST_DONE) begin
        useY        <= 1'b0;
        indirect    <= 1'b0;
        extraCycles <= 2'd0;
      end
    end
  end

  always_comb begin
    strb            = '0;
    strb.firstByte  = (state == ST_OPC) && !prefSeen;
    strb.takeByte   = take;
    strb.capOp1     = take && (state == ST_OP1);
    strb.capOp2     = take && (state == ST_OP2);
    strb.capPtrHi   = memValid && (state == ST_RD1) && isLongMode(mode);
    strb.capPtrLo   = memValid && (((state == ST_RD1) && !isLongMode(mode)) || (state == ST_RD2));
    strb.ptrPlusOne = (state == ST_RD2);
  end

  // R14: the completion strobe never lasts two cycles
  assert_pulse_R14: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done held longer than one cycle");

  // R5: a byte taken after a prefix always ends prefix handling
  assert_second_prefix_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OPC && take && prefSeen) |=> (!prefSeen && state != ST_OPC))
    else $error("prefix handling continued past the opcode");

endmodule

// File: rtl/eag_dp.sv
module eag_dp
  import eag_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  eagStrobe_t    strb,
  input  eaMode_t       mode,
  input  logic          useY,
  input  logic          indirect,
  input  logic [DW-1:0] fetchByte,
  input  logic [AW-1:0] instrPc,
  input  logic [DW-1:0] memData,
  input  logic [DW-1:0] xIdx,
  input  logic [DW-1:0] yIdx,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] ea
);

  localparam int HW = AW - DW;

  logic [AW-1:0] curPc, immAddr, bytePc;
  logic [DW-1:0] op1, op2, ptrHi, ptrLo;
  logic [AW-1:0] idxVal, shortBase, longBase;

  assign bytePc = strb.firstByte ? instrPc : curPc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPc   <= '0;
      immAddr <= '0;
      op1     <= '0;
      op2     <= '0;
      ptrHi   <= '0;
      ptrLo   <= '0;
    end else begin
      if (strb.takeByte) curPc <= bytePc + AW'(1);
      if (strb.capOp1) begin
        op1     <= fetchByte;
        immAddr <= bytePc;
      end
      if (strb.capOp2)   op2   <= fetchByte;
      if (strb.capPtrHi) ptrHi <= memData;
      if (strb.capPtrLo) ptrLo <= memData;
    end
  end

  assign memAddr   = {{HW{1'b0}}, op1} + AW'(strb.ptrPlusOne);
  assign idxVal    = {{HW{1'b0}}, (useY ? yIdx : xIdx)};
  assign shortBase = indirect ? {{HW{1'b0}}, ptrLo} : {{HW{1'b0}}, op1};
  assign longBase  = indirect ? {ptrHi, ptrLo} : {op1, op2};

  always_comb begin
    case (mode)
      MD_IMM:            ea = immAddr;
      MD_DIR8, MD_BIT:   ea = shortBase;
      MD_DIR16:          ea = longBase;
      MD_IDX16:          ea = longBase + idxVal;
      MD_IDX8:           ea = shortBase + idxVal;
      MD_IDXONLY:        ea = idxVal;
      default:           ea = '0;
    endcase
  end

  // R6: the running fetch address moves on past the captured immediate byte
  assert_imm_pc_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.capOp1 |=> (curPc == immAddr + AW'(1)))
    else $error("fetch address out of step with operand address");

endmodule

// File: rtl/prefix_ea_gen.sv
module prefix_ea_gen
  import eag_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] PFX_Y     = 8'h90,
  parameter logic [DW-1:0] PFX_Y_IND = 8'h91,
  parameter logic [DW-1:0] PFX_IND   = 8'h92,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fetchValid,
  input  logic [DW-1:0] fetchByte,
  input  logic [AW-1:0] instrPc,
  output logic          fetchReady,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  input  logic          memValid,
  input  logic [DW-1:0] memData,
  input  logic [DW-1:0] xIdx,
  input  logic [DW-1:0] yIdx,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic [3:0]    mode,
  output logic          useY,
  output logic [1:0]    extraCycles
);

  eagStrobe_t strb;
  eaMode_t    modeInt;
  logic       indirect;

  eag_ctrl #(.DW(DW), .PFX_Y(PFX_Y), .PFX_Y_IND(PFX_Y_IND), .PFX_IND(PFX_IND)) u_ctrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchByte(fetchByte),
    .memValid(memValid), .fetchReady(fetchReady), .memReq(memReq), .done(done),
    .useY(useY), .indirect(indirect), .extraCycles(extraCycles), .mode(modeInt), .strb(strb)
  );

  eag_dp #(.DW(DW), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mode(modeInt), .useY(useY), .indirect(indirect),
    .fetchByte(fetchByte), .instrPc(instrPc), .memData(memData), .xIdx(xIdx), .yIdx(yIdx),
    .memAddr(memAddr), .ea(ea)
  );

  assign mode = modeInt;

  // R13: an outstanding read holds its address
  assert_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memAddr)))
    else $error("pointer read dropped or moved");

  // R2: a one-cycle cost only comes from the Y prefix
  assert_extra_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (done && extraCycles == 2'd1) |-> useY) else $error("one extra cycle without Y");

  // R4: without a prefix the index is X
  assert_no_prefix_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && extraCycles == 2'd0) |-> !useY) else $error("Y selected without a prefix");

  // R11: modes without an operand address report zero
  assert_noaddr_R11: assert property (@(posedge clk) disable iff (!rstN)
    (done && (mode == 4'd0 || mode == 4'd7 || mode == 4'd8)) |-> (ea == '0))
    else $error("address reported for a no-address mode");

  // R8: index-only mode reports the selected index register
  assert_idx_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && mode == 4'd6) |-> (ea == {{DW{1'b0}}, (useY ? yIdx : xIdx)}))
    else $error("index-only address differs from index");

endmodule

// File: tb/prefix_ea_gen_bench.sv
module prefix_ea_gen_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        fetchValid;
  logic [7:0]  fetchByte;
  logic [15:0] instrPc;
  logic        fetchReady, memReq, memValid, done, useY;
  logic [15:0] memAddr, ea;
  logic [7:0]  memData, xIdx, yIdx;
  logic [3:0]  mode;
  logic [1:0]  extraCycles;
  logic        memOk;

  always #5 clk = ~clk;

  prefix_ea_gen u_prefix_ea_gen (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchByte(fetchByte),
    .instrPc(instrPc), .fetchReady(fetchReady), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData), .xIdx(xIdx), .yIdx(yIdx), .done(done),
    .ea(ea), .mode(mode), .useY(useY), .extraCycles(extraCycles)
  );

  typedef struct {
    int    eaV; int modeV; int useYV; int extraV; int readsV;
    string eaTag; string pfxTag; string rdTag;
  } expRec_t;

  expRec_t    expQ[$];
  logic [7:0] byteQ[$];
  int errors = 0, checks = 0, cycles = 0;
  int headPc = 0, tailPc = 0, readsSeen = 0, xv = 0, yv = 0;
  logic pendTake = 1'b0, holdPend = 1'b0, prevDone = 1'b0;
  logic [15:0] holdAddr = '0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [7:0] memf(input logic [15:0] a);
    logic [15:0] t;
    t = (a * 16'd29) ^ (a >> 5) ^ 16'h03C5;
    return t[7:0] ^ t[15:8];
  endfunction

  assign memData  = memf(memAddr);
  assign memValid = memReq & memOk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finishUp;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic int modeOfNib(input int n);
    case (n)
      0, 1:   return 9;
      3, 11:  return 2;
      4:      return 7;
      5:      return 8;
      6, 14:  return 5;
      7, 15:  return 6;
      10:     return 1;
      12:     return 3;
      13:     return 4;
      default: return 0;
    endcase
  endfunction

  task automatic pushByte(input int b);
    byteQ.push_back(b[7:0]);
    tailPc = (tailPc + 1) & 16'hFFFF;
  endtask

  // pfx < 0 means no prefix byte
  task automatic addInstr(input int pfx, input int opc, input int o1, input int o2);
    expRec_t e;
    int ind, idx, base, opcPc;
    e.useYV  = (pfx == 8'h90 || pfx == 8'h91) ? 1 : 0;
    ind      = (pfx == 8'h91 || pfx == 8'h92) ? 1 : 0;
    e.extraV = (pfx < 0) ? 0 : ((pfx == 8'h90) ? 1 : 2);
    e.pfxTag = (pfx == 8'h90) ? "R2" : (pfx == 8'h91) ? "R3" : "R4";
    if (pfx >= 0 && opc >= 8'h90 && opc <= 8'h92) e.pfxTag = "R5";
    if (pfx >= 0) pushByte(pfx);
    opcPc = tailPc;
    pushByte(opc);
    e.modeV  = modeOfNib(opc >> 4);
    idx      = e.useYV ? yv : xv;
    e.readsV = 0;
    e.eaV    = 0;
    e.eaTag  = "R11";
    case (e.modeV)
      1: begin pushByte(o1); e.eaV = (opcPc + 1) & 16'hFFFF; e.eaTag = "R6"; end
      2, 9: begin
        pushByte(o1);
        if (ind) begin e.eaV = memf(16'(o1)); e.readsV = 1; e.eaTag = "R9"; end
        else begin e.eaV = o1; e.eaTag = "R7"; end
      end
      5: begin
        pushByte(o1);
        base = ind ? memf(16'(o1)) : o1;
        if (ind) e.readsV = 1;
        e.eaV = (base + idx) & 16'hFFFF; e.eaTag = ind ? "R9" : "R8";
      end
      3, 4: begin
        pushByte(o1);
        if (ind) begin
          base = (memf(16'(o1)) << 8) | memf(16'(o1 + 1));
          e.readsV = 2; e.eaTag = "R10";
        end else begin
          pushByte(o2);
          base = (o1 << 8) | o2;
          e.eaTag = (e.modeV == 3) ? "R7" : "R8";
        end
        e.eaV = (e.modeV == 4) ? ((base + idx) & 16'hFFFF) : base;
      end
      6: begin e.eaV = idx; e.eaTag = "R8"; end
      default: ;
    endcase
    e.rdTag = (e.readsV == 2) ? "R10" : (e.readsV == 1) ? "R9" : "R11";
    expQ.push_back(e);
  endtask

  task automatic runLoop;
    expRec_t e;
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finishUp();
      end
      if (pendTake) begin
        void'(byteQ.pop_front());
        headPc = (headPc + 1) & 16'hFFFF;
      end
      lfsr       = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fetchValid = (byteQ.size() > 0) && (lfsr[0] | lfsr[1]);
      fetchByte  = (byteQ.size() > 0) ? byteQ[0] : 8'h00;
      instrPc    = headPc[15:0];
      memOk      = lfsr[2] | lfsr[5];
      #1;
      pendTake = fetchValid && fetchReady;
      if (holdPend) begin
        check("R13 request held", int'(memReq), 1);
        check("R13 address stable", int'(memAddr), int'(holdAddr));
      end
      holdPend = memReq && !memValid;
      holdAddr = memAddr;
      if (done) begin
        check("R14 single-cycle done", int'(prevDone), 0);
        check("R14 no fetch during done", int'(fetchReady), 0);
        if (expQ.size() == 0) check("R14 unexpected done", 1, 0);
        else begin
          e = expQ.pop_front();
          check({e.eaTag, " ea"}, int'(ea), e.eaV);
          check("R12 mode tag", int'(mode), e.modeV);
          check({e.pfxTag, " index select"}, int'(useY), e.useYV);
          check({e.pfxTag, " extra cycles"}, int'(extraCycles), e.extraV);
          check({e.rdTag, " pointer reads"}, readsSeen, e.readsV);
        end
        readsSeen = 0;
      end
      prevDone = done;
      if (memReq && memValid) readsSeen++;
    end
  endtask

  task automatic waitIdle;
    while (expQ.size() > 0 || byteQ.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic setIdx(input int xn, input int yn);
    xv = xn; yv = yn;
    xIdx = xn[7:0]; yIdx = yn[7:0];
  endtask

  initial begin
    rstN = 1'b0; fetchValid = 1'b0; fetchByte = 8'h00; instrPc = 16'h0000; memOk = 1'b0;
    setIdx(8'h05, 8'h20);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 fetchReady after reset", int'(fetchReady), 1);
    check("R1 memReq after reset", int'(memReq), 0);
    check("R1 done after reset", int'(done), 0);
    headPc = 16'h0100; tailPc = 16'h0100;
    fork runLoop(); join_none

    // directed cases
    addInstr(-1, 8'hA6, 8'h42, 0);        // R6 immediate
    addInstr(-1, 8'hB6, 8'h80, 0);        // R7 short direct
    addInstr(-1, 8'hC6, 8'h12, 8'h34);    // R7 long direct
    addInstr(8'h90, 8'hD6, 8'hFF, 8'hF0); // R8 wrap, R2
    addInstr(8'h90, 8'hF6, 0, 0);         // R8 index only Y
    addInstr(8'h92, 8'hB6, 8'h33, 0);     // R9 short indirect, R4
    addInstr(8'h91, 8'hE6, 8'h40, 0);     // R9 short indirect indexed, R3
    addInstr(8'h92, 8'hC6, 8'hFF, 0);     // R10 pointer crossing to 0x100
    addInstr(8'h91, 8'hD6, 8'h10, 0);     // R10 long indirect indexed
    addInstr(8'h92, 8'h12, 8'h55, 0);     // R9 bit form indirect
    addInstr(8'h92, 8'h4C, 0, 0);         // R11 inherent
    addInstr(8'h92, 8'hA6, 8'h77, 0);     // R11 immediate ignores indirect
    addInstr(8'h90, 8'h92, 0, 0);         // R5 second prefix as opcode
    addInstr(8'h91, 8'h91, 0, 0);         // R5
    addInstr(8'h92, 8'h7F, 0, 0);         // R11 index only ignores indirect
    waitIdle();

    // immediate operand across the top of memory
    headPc = 16'hFFFE; tailPc = 16'hFFFE;
    addInstr(8'h92, 8'hA6, 8'h11, 0);     // R6 ea wraps to 0
    waitIdle();

    for (int b = 0; b < 4; b++) begin
      case (b)
        0: setIdx(8'h00, 8'hFF);
        1: setIdx(8'hFF, 8'h00);
        2: setIdx(8'h7F, 8'h80);
        default: setIdx(8'h3C, 8'hC3);
      endcase
      for (int i = 0; i < 80; i++) begin
        int r, pfx, opc;
        r   = $urandom % 4;
        pfx = (r == 0) ? -1 : (8'h8F + r);
        opc = $urandom % 256;
        if (pfx < 0 && opc >= 8'h90 && opc <= 8'h92) opc = 8'h9D;
        addInstr(pfx, opc, $urandom % 256, $urandom % 256);
      end
      waitIdle();
    end
    finishUp();
  end

endmodule